// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A small synchronous binary up-counter, four bits wide by default, that can be loaded in parallel and chained into wider counters with no glue logic between stages. Every state bit changes on the rising clock edge, so all outputs move together. An active-low clear returns the count to zero. An active-low load copies a data word into the count. Two active-high count enables must both be high for the counter to advance.

Only the second enable, the cascade enable, gates the carry output. The carry goes high when that enable is high and the count is all ones. It is formed combinationally from the current count, so a chain can be built by wiring each stage's carry into the next stage's cascade enable. A build-time parameter makes the clear act either at once, independent of the clock, or on the next rising edge. With the synchronous form, decoding count N-1 onto the clear gives a modulo-N counter.

Top module: `presettable_counter`

## Requirements
- R1: The count changes only on a rising clock edge. A change on the data or load inputs between edges leaves the count unchanged until the next edge.
- R2: When load is low and clear is high, the next rising edge puts the data input into the count, whatever levels the two enables have.
- R3: With SYNC_CLEAR = 0, a low clear sets the count to zero without waiting for a clock edge, and keeps it at zero across edges while load is low.
- R4: With SYNC_CLEAR = 1, a low clear leaves the count unchanged until the next rising edge and then sets it to zero, taking priority over load and the enables. An external decode of count N-1 onto the clear gives a repeating cycle 0 to N-1.
- R5: With clear and load high, and both enables high, the count goes up by one on each rising edge.
- R6: With clear and load high, the count holds if either enable is low.
- R7: The carry is high exactly when the cascade enable is high and the count is all ones (15 for the default width). The count enable has no effect on the carry.
- R8: The count wraps from all ones to zero. After a preset to 12 with both enables high, it runs 13, 14, 15, 0, 1, 2.
- R9: Two stages chain into an 8-bit counter when the low stage's carry drives the high stage's cascade enable and both count enables are tied high. The pair counts 0 to 255 and wraps, and the high stage advances on the same edge where the low stage wraps.
- R10: The carry follows a change of the cascade enable within the same clock cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous according to SYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel preset value |
| en_cnt | input | 1 | Count enable; does not gate the carry |
| en_casc | input | 1 | Cascade enable; gates both counting and the carry |
| count | output | WIDTH | Current count |
| carry | output | 1 | High when en_casc is high and count is all ones |

## Verification
Every preset value from 0 to 15 is loaded. For each one the bench tries all four enable combinations and checks the hold, the increment and the carry, which separates the role of the count enable from that of the cascade enable. A preset-12 run shows the wrap, and a mid-cycle change of the data and load inputs shows that nothing happens between edges. A mid-cycle clear is checked on both builds: the asynchronous build clears at once, and the synchronous build clears only at the next edge. A decoded modulo-6 loop and a two-stage chain stepped past 255 test the clear priority and the same-edge cascading.

// File: rtl/presettable_counter.sv
module presettable_counter #(
  parameter int WIDTH      = 4,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_cnt,
  input  logic             en_casc,
  output logic [WIDTH-1:0] count,
  output logic             carry
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = count;
    if (!load_n)                nxt = din;
    else if (en_cnt && en_casc) nxt = count + ONE;
  end

  generate
    if (SYNC_CLEAR) begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (!clr_n) count <= '0;
        else        count <= nxt;
      end

      a_r4_sync_clear: assert property (@(posedge clk)
        !clr_n |=> count == '0);
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) count <= '0;
        else        count <= nxt;
      end

      a_r3_async_clear: assert property (@(posedge clk)
        !clr_n |-> count == '0);
    end
  endgenerate

  assign carry = en_casc & (&count);

  a_r2_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(din));

  a_r5_increment: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_cnt && en_casc) |=> count == WIDTH'($past(count) + ONE));

  a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_cnt && en_casc)) |=> $stable(count));

endmodule

// File: tb/test_presettable_counter.sv
module test_presettable_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       clr_n = 1'b0, load_n = 1'b1, en_cnt = 1'b0, en_casc = 1'b0, mod_mode = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q;
  logic       cy;
  logic       dut_clr;
  assign dut_clr = mod_mode ? (q != 4'd5) : clr_n;

  presettable_counter #(.WIDTH(4), .SYNC_CLEAR(1'b1)) i_presettable_counter (
    .clk(clk), .clr_n(dut_clr), .load_n(load_n), .din(din),
    .en_cnt(en_cnt), .en_casc(en_casc), .count(q), .carry(cy));

  logic       a_clr_n = 1'b1, a_load_n = 1'b1;
  logic [3:0] a_din = '0;
  logic [3:0] aq;
  logic       acy;
  presettable_counter #(.WIDTH(4), .SYNC_CLEAR(1'b0)) i_async (
    .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .din(a_din),
    .en_cnt(1'b0), .en_casc(1'b0), .count(aq), .carry(acy));

  logic       c_clr_n = 1'b0;
  logic [3:0] lq, hq;
  logic       lcy, hcy;
  presettable_counter #(.WIDTH(4), .SYNC_CLEAR(1'b1)) i_low (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
    .en_cnt(1'b1), .en_casc(1'b1), .count(lq), .carry(lcy));
  presettable_counter #(.WIDTH(4), .SYNC_CLEAR(1'b1)) i_high (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
    .en_cnt(1'b1), .en_casc(lcy), .count(hq), .carry(hcy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrap_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    #1 a_clr_n = 1'b0;
    step();
    chk("R4 reset count", int'(q), 0);
    chk("R7 reset carry", int'(cy), 0);
    chk("R3 async reset", int'(aq), 0);

    clr_n = 1'b1; load_n = 1'b0; din = 4'd12;
    step();
    chk("R2 load enables low", int'(q), 12);
    en_cnt = 1'b1; en_casc = 1'b1; din = 4'd5;
    step();
    chk("R2 load enables high", int'(q), 5);

    din = 4'd9;
    #1 chk("R1 no change between edges", int'(q), 5);
    step();
    chk("R1 update at edge", int'(q), 9);
    load_n = 1'b1;

    for (int v = 0; v < 16; v++) begin
      load_n = 1'b0; din = 4'(v); en_cnt = 1'b0; en_casc = 1'b0;
      step();
      load_n = 1'b1;
      chk("R7 carry off when cascade enable low", int'(cy), 0);
      en_casc = 1'b1;
      #1 chk("R10 carry follows cascade enable", int'(cy), (v == 15) ? 1 : 0);
      step();
      chk("R6 hold count enable low", int'(q), v);
      chk("R7 carry independent of count enable", int'(cy), (v == 15) ? 1 : 0);
      en_cnt = 1'b1; en_casc = 1'b0;
      step();
      chk("R6 hold cascade enable low", int'(q), v);
      en_casc = 1'b1;
      #1 chk("R7 carry with both enables", int'(cy), (v == 15) ? 1 : 0);
      step();
      chk("R5 increment", int'(q), (v + 1) % 16);
    end

    load_n = 1'b0; din = 4'd12;
    step();
    load_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      step();
      chk("R8 wrap sequence", int'(q), (12 + k) % 16);
    end

    clr_n = 1'b0; load_n = 1'b0; din = 4'd7;
    #1 chk("R4 clear waits for edge", int'(q), 2);
    step();
    chk("R4 clear beats load", int'(q), 0);
    clr_n = 1'b1; load_n = 1'b1;

    mod_mode = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      step();
      chk("R4 modulo-6 cycle", int'(q), k % 6);
    end
    mod_mode = 1'b0;

    a_clr_n = 1'b1; a_load_n = 1'b0; a_din = 4'd9;
    step();
    chk("R3 async build load", int'(aq), 9);
    a_clr_n = 1'b0;
    #1 chk("R3 async clear immediate", int'(aq), 0);
    step();
    chk("R3 async clear holds over load", int'(aq), 0);
    a_clr_n = 1'b1; a_load_n = 1'b1;

    c_clr_n = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      step();
      chk("R9 cascaded count", int'({hq, lq}), i % 256);
    end

    wrap_up();
  end
endmodule